// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a clocked host perform single word reads and writes on an external asynchronous static RAM of 2^18 words by 4 bits. The host raises a request with a direction flag, an address and, for writes, the data. The controller accepts the request when its ready output is high. It then sequences the active-low chip-select, write-strobe and output-enable pins so that every setup, pulse-width, access and bus-turnaround minimum of the memory is met. For reads it returns the word with a one-cycle valid pulse.

All memory timing minimums are parameters counted in clock cycles. By default each is derived from a nanosecond figure and the clock period, rounded up to whole cycles. Only one access is in flight at a time. A request that arrives while the controller is busy waits, with the host holding it, until ready returns. The shared 4-bit data bus is driven by the controller only inside a write strobe. A read captures the bus contents into a register on the clock edge at which the access time has elapsed.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, chip select, write strobe and output enable are all high, ready is high and read-valid is low.
- R2: Pin encoding (all active low) is always one of: standby (chip select, write strobe and output enable high), read (chip select low, write strobe high, output enable low), write (chip select low, write strobe low, output enable high), or outputs disabled (chip select low, both strobes high).
- R3: A write holds the write strobe low for exactly max(write pulse, data setup) cycles, 3 at the default 4 ns clock, with address and bus data stable throughout.
- R4: A read holds output enable low for exactly max(address access, select access, enable access) cycles, 3 by default. On the edge that ends it the bus is captured and read-valid pulses for one cycle with the stored word on the read-data output.
- R5: The write strobe falls only after output enable has been high for at least the turnaround count, 2 cycles by default.
- R6: The controller drives the data bus only while the write strobe is low and output enable is high, and during that time the bus carries the accepted write word.
- R7: Ready is high only while the memory is in standby. A request is accepted on an edge where request and ready are both high.
- R8: A request presented while ready is low is held off, not dropped: every request performs exactly one memory access, and every read produces exactly one valid pulse.
- R9: The memory address is loaded on the accept edge, equals the requested address, and is stable for the whole time chip select is low.
- R10: Ready stays low for at least the cycle-time count, 3 by default, after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, held until accepted |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | 4 | Write word |
| host_ready | output | 1 | Controller can accept a request |
| host_rdata | output | 4 | Captured read word |
| host_rvalid | output | 1 | One-cycle pulse: host_rdata valid |
| sram_cs_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_addr | output | 18 | Memory address |
| sram_dq | inout | 4 | Bidirectional memory data bus |

## Verification
The properties assume the host holds its request, direction, address and data steady from the cycle it raises the request until the accept edge. They also assume the memory drives the bus only while chip select and output enable are low and the write strobe is high. The stimulus meets the first assumption by changing host inputs only on falling clock edges and only before acceptance. The bench memory model meets the second by gating its bus driver on exactly those three pins. Random traffic mixes reads and writes over a small address pool, with occasional full-range addresses and idle gaps of zero to two cycles. Back-to-back requests therefore exercise both the held-off path and the read-to-write turnaround wait.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR_TA,
      ST_WR,
      ST_RD,
      ST_RECOV
   } sram_st_e;

   // whole cycles covering a nanosecond minimum; zero stays zero
   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      if (ns <= 0) return 0;
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_dly_cnt.sv
module sram_dly_cnt #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ta_track.sv
module sram_ta_track #(
   parameter int TURN_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oe_n,
   output logic ta_ok
);

   localparam int TAW = $clog2(TURN_CYC + 1);
   localparam logic [TAW-1:0] TA_SAT = TAW'(TURN_CYC);
   localparam logic [TAW-1:0] TA_THR = TAW'(TURN_CYC - 1);

   logic [TAW-1:0] ta_q;

   // cycles output enable has been high, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ta_q <= TA_SAT;
      end else if (!oe_n) begin
         ta_q <= '0;
      end else if (ta_q < TA_SAT) begin
         ta_q <= ta_q + TAW'(1);
      end
   end

   // strobe set on this edge sees oe_n high for TURN_CYC cycles
   assign ta_ok = oe_n && (ta_q >= TA_THR);

endmodule

// File: rtl/sram_dq_io.sv
module sram_dq_io #(
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drv_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              capture,
   output logic [DATA_W-1:0] rdata,
   inout  wire  [DATA_W-1:0] dq
);

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign dq[b] = drv_en ? wdata[b] : 1'bz;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (capture) begin
         rdata <= dq;
      end
   end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W     = 18,
   parameter int DATA_W     = 4,
   parameter int CLK_NS     = 4,
   parameter int T_WP_CYC   = ns_to_cyc(10, CLK_NS),
   parameter int T_DS_CYC   = ns_to_cyc(7,  CLK_NS),
   parameter int T_AA_CYC   = ns_to_cyc(12, CLK_NS),
   parameter int T_ACS_CYC  = ns_to_cyc(12, CLK_NS),
   parameter int T_OE_CYC   = ns_to_cyc(6,  CLK_NS),
   parameter int T_CYC_CYC  = ns_to_cyc(12, CLK_NS),
   parameter int T_TURN_CYC = ns_to_cyc(5,  CLK_NS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              host_ready,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_rvalid,
   output logic              sram_cs_n,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   output logic [ADDR_W-1:0] sram_addr,
   inout  wire  [DATA_W-1:0] sram_dq
);

   localparam int RD_EFF = imax(imax(T_AA_CYC, T_ACS_CYC), T_OE_CYC);
   localparam int WP_EFF = imax(T_WP_CYC, T_DS_CYC);
   localparam int OP_MAX = imax(RD_EFF, WP_EFF);
   localparam int OPW    = $clog2(OP_MAX + 1);
   localparam int CYW    = $clog2(T_CYC_CYC + 1);
   localparam logic [OPW-1:0] RD_LOAD  = OPW'(RD_EFF - 1);
   localparam logic [OPW-1:0] WP_LOAD  = OPW'(WP_EFF - 1);
   localparam logic [CYW-1:0] CYC_LOAD = CYW'(T_CYC_CYC - 1);

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_async_ctrl: ADDR_W and DATA_W must be at least 1");
   end
   if (RD_EFF < 1 || WP_EFF < 1) begin : g_bad_access
      $error("sram_async_ctrl: read and write windows need at least one cycle");
   end
   if (T_CYC_CYC < 1) begin : g_bad_cycle
      $error("sram_async_ctrl: T_CYC_CYC must be at least 1");
   end
   if (T_TURN_CYC < 1) begin : g_bad_turn
      $error("sram_async_ctrl: T_TURN_CYC must be at least 1");
   end

   sram_st_e          st_q, st_d;
   logic              cs_n_q, cs_d;
   logic              we_n_q, we_d;
   logic              oe_n_q, oe_d;
   logic              drv_q, drv_d;
   logic              ready_q, rdy_d;
   logic              rvalid_q, rv_d;
   logic [ADDR_W-1:0] addr_q, addr_d;
   logic [DATA_W-1:0] wdata_q, wd_d;

   logic              op_load, op_zero;
   logic [OPW-1:0]    op_val;
   logic              cyc_load, cyc_zero;
   logic              ta_ok;
   logic              capture;
   logic              accept;

   sram_dly_cnt #(.W(OPW)) u_op_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (op_load),
      .load_val (op_val),
      .zero     (op_zero)
   );

   sram_dly_cnt #(.W(CYW)) u_cyc_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cyc_load),
      .load_val (CYC_LOAD),
      .zero     (cyc_zero)
   );

   sram_ta_track #(.TURN_CYC(T_TURN_CYC)) u_ta (
      .clk   (clk),
      .rst_n (rst_n),
      .oe_n  (oe_n_q),
      .ta_ok (ta_ok)
   );

   sram_dq_io #(.DATA_W(DATA_W)) u_io (
      .clk     (clk),
      .rst_n   (rst_n),
      .drv_en  (drv_q),
      .wdata   (wdata_q),
      .capture (capture),
      .rdata   (host_rdata),
      .dq      (sram_dq)
   );

   assign accept = ready_q && host_req;

   always_comb begin
      st_d     = st_q;
      cs_d     = cs_n_q;
      we_d     = we_n_q;
      oe_d     = oe_n_q;
      drv_d    = drv_q;
      rdy_d    = ready_q;
      rv_d     = 1'b0;
      addr_d   = addr_q;
      wd_d     = wdata_q;
      op_load  = 1'b0;
      op_val   = '0;
      cyc_load = 1'b0;
      capture  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (accept) begin
               cs_d     = 1'b0;
               rdy_d    = 1'b0;
               addr_d   = host_addr;
               cyc_load = 1'b1;
               if (host_we) begin
                  wd_d = host_wdata;
                  if (ta_ok) begin
                     we_d    = 1'b0;
                     drv_d   = 1'b1;
                     op_load = 1'b1;
                     op_val  = WP_LOAD;
                     st_d    = ST_WR;
                  end else begin
                     st_d = ST_WR_TA;
                  end
               end else begin
                  oe_d    = 1'b0;
                  op_load = 1'b1;
                  op_val  = RD_LOAD;
                  st_d    = ST_RD;
               end
            end
         end
         ST_WR_TA: begin
            if (ta_ok) begin
               we_d    = 1'b0;
               drv_d   = 1'b1;
               op_load = 1'b1;
               op_val  = WP_LOAD;
               st_d    = ST_WR;
            end
         end
         ST_WR: begin
            if (op_zero) begin
               we_d  = 1'b1;
               drv_d = 1'b0;
               cs_d  = 1'b1;
               if (cyc_zero) begin
                  rdy_d = 1'b1;
                  st_d  = ST_IDLE;
               end else begin
                  st_d = ST_RECOV;
               end
            end
         end
         ST_RD: begin
            if (op_zero) begin
               capture = 1'b1;
               rv_d    = 1'b1;
               oe_d    = 1'b1;
               cs_d    = 1'b1;
               if (cyc_zero) begin
                  rdy_d = 1'b1;
                  st_d  = ST_IDLE;
               end else begin
                  st_d = ST_RECOV;
               end
            end
         end
         ST_RECOV: begin
            if (cyc_zero) begin
               rdy_d = 1'b1;
               st_d  = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         cs_n_q   <= 1'b1;
         we_n_q   <= 1'b1;
         oe_n_q   <= 1'b1;
         drv_q    <= 1'b0;
         ready_q  <= 1'b1;
         rvalid_q <= 1'b0;
         addr_q   <= '0;
         wdata_q  <= '0;
      end else begin
         st_q     <= st_d;
         cs_n_q   <= cs_d;
         we_n_q   <= we_d;
         oe_n_q   <= oe_d;
         drv_q    <= drv_d;
         ready_q  <= rdy_d;
         rvalid_q <= rv_d;
         addr_q   <= addr_d;
         wdata_q  <= wd_d;
      end
   end

   assign host_ready  = ready_q;
   assign host_rvalid = rvalid_q;
   assign sram_cs_n   = cs_n_q;
   assign sram_we_n   = we_n_q;
   assign sram_oe_n   = oe_n_q;
   assign sram_addr   = addr_q;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
   parameter int ADDR_W   = 18,
   parameter int DATA_W   = 4,
   parameter int TURN_CYC = 2,
   parameter int CYC_CYC  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_ready,
   input logic              host_rvalid,
   input logic              sram_cs_n,
   input logic              sram_we_n,
   input logic              sram_oe_n,
   input logic [ADDR_W-1:0] sram_addr,
   input logic [DATA_W-1:0] sram_dq,
   input logic              drv_en
);

   localparam int RW = $clog2(TURN_CYC + 1);
   localparam int BW = $clog2(CYC_CYC + 1);
   localparam logic [RW-1:0] RUN_SAT  = RW'(TURN_CYC);
   localparam logic [BW-1:0] BUSY_SAT = BW'(CYC_CYC);

   logic [RW-1:0] oe_hi_run;
   logic [BW-1:0] busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_hi_run <= RUN_SAT;
         busy_run  <= '0;
      end else begin
         if (!sram_oe_n)          oe_hi_run <= '0;
         else if (oe_hi_run < RUN_SAT) oe_hi_run <= oe_hi_run + RW'(1);
         if (host_ready)          busy_run <= '0;
         else if (busy_run < BUSY_SAT) busy_run <= busy_run + BW'(1);
      end
   end

   // R2: pin combinations
   a_r2_write_code: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> (!sram_cs_n && sram_oe_n));
   a_r2_read_code: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> (!sram_cs_n && sram_we_n));
   a_r2_standby: assert property (@(posedge clk) disable iff (!rst_n)
      sram_cs_n |-> (sram_we_n && sram_oe_n));

   // R3: bus word steady inside a strobe
   a_r3_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_dq));

   // R4: valid is a single pulse after the access has closed
   a_r4_rvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      host_rvalid |=> !host_rvalid);
   a_r4_rvalid_closed: assert property (@(posedge clk) disable iff (!rst_n)
      host_rvalid |-> (sram_oe_n && sram_cs_n));

   // R5: turnaround before a strobe
   a_r5_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_we_n) |-> (oe_hi_run >= RUN_SAT));

   // R6: driver window
   a_r6_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en |-> (!sram_we_n && sram_oe_n));

   // R7: ready only in standby
   a_r7_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> (sram_cs_n && sram_we_n && sram_oe_n));

   // R9: address held while selected
   a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

   // R10: minimum busy span
   a_r10_cycle_min: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_ready) |-> (busy_run >= BUSY_SAT));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .TURN_CYC (T_TURN_CYC),
   .CYC_CYC  (T_CYC_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_ready  (host_ready),
   .host_rvalid (host_rvalid),
   .sram_cs_n   (sram_cs_n),
   .sram_we_n   (sram_we_n),
   .sram_oe_n   (sram_oe_n),
   .sram_addr   (sram_addr),
   .sram_dq     (sram_dq),
   .drv_en      (drv_q)
);

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;

   // expected windows at a 4 ns clock, from the nanosecond minimums
   localparam int E_WP   = (10 + 3) / 4;
   localparam int E_DS   = (7 + 3) / 4;
   localparam int E_WIN  = (E_WP > E_DS) ? E_WP : E_DS;
   localparam int E_RD   = (12 + 3) / 4;
   localparam int E_CYC  = (12 + 3) / 4;
   localparam int E_TURN = (5 + 3) / 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0;
   logic        host_we = 1'b0;
   logic [17:0] host_addr = '0;
   logic [3:0]  host_wdata = '0;
   logic        host_ready;
   logic [3:0]  host_rdata;
   logic        host_rvalid;
   logic        sram_cs_n, sram_we_n, sram_oe_n;
   logic [17:0] sram_addr;
   wire  [3:0]  sram_dq;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   sram_async_ctrl u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_req    (host_req),
      .host_we     (host_we),
      .host_addr   (host_addr),
      .host_wdata  (host_wdata),
      .host_ready  (host_ready),
      .host_rdata  (host_rdata),
      .host_rvalid (host_rvalid),
      .sram_cs_n   (sram_cs_n),
      .sram_we_n   (sram_we_n),
      .sram_oe_n   (sram_oe_n),
      .sram_addr   (sram_addr),
      .sram_dq     (sram_dq)
   );

   // ---------------- memory model ----------------
   logic [3:0] mdl_mem [int];
   logic [3:0] exp_mem [int];
   logic [3:0] mdl_q = '0;

   function automatic logic [3:0] dflt(input logic [17:0] a);
      return a[3:0] ^ a[17:14] ^ 4'h5;
   endfunction

   assign sram_dq = (!sram_cs_n && sram_we_n && !sram_oe_n) ? mdl_q : 4'bz;

   always @(negedge clk) begin
      if (rst_n && !sram_cs_n && !sram_we_n)
         mdl_mem[int'(sram_addr)] = sram_dq;
      if (rst_n && !sram_cs_n && !sram_oe_n)
         mdl_q = mdl_mem.exists(int'(sram_addr)) ? mdl_mem[int'(sram_addr)]
                                                  : dflt(sram_addr);
   end

   // ---------------- checking helpers ----------------
   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   // ---------------- port monitor ----------------
   logic [17:0] cur_addr = '0;
   logic [3:0]  cur_wdata = '0;
   bit  started = 0;
   bit  p_we = 1, p_oe = 1, p_cs = 1, p_rdy = 1, p_rv = 0;
   int  we_run = 0, oe_lo_run = 0, oe_hi_run = 1000, busy_run = 0;
   int  n_cs_fall = 0, n_rv = 0, n_req = 0, n_reads = 0;
   int  enc_bad = 0, rdy_bad = 0, addr_bad = 0, drv_bad = 0;

   always @(negedge clk) begin
      if (started) begin
         // R2 pin encoding
         if ((!sram_we_n && (sram_cs_n || !sram_oe_n)) ||
             (!sram_oe_n && (sram_cs_n || !sram_we_n)) ||
             (sram_cs_n && (!sram_we_n || !sram_oe_n)))
            enc_bad++;
         // R7 ready only in standby
         if (host_ready && !(sram_cs_n && sram_we_n && sram_oe_n)) rdy_bad++;
         // R9 address while selected
         if (!sram_cs_n && sram_addr != cur_addr) addr_bad++;
         // R6 bus carries the write word inside the strobe
         if (!sram_we_n && sram_dq != cur_wdata) drv_bad++;
         if (!sram_cs_n && p_cs) n_cs_fall++;

         // R5 turnaround before the strobe falls
         if (!sram_we_n && p_we)
            check(oe_hi_run >= E_TURN, "R5 turnaround", oe_hi_run, E_TURN);
         // R3 strobe width
         if (!sram_we_n) we_run++;
         if (sram_we_n && !p_we)
            check(we_run == E_WIN, "R3 strobe width", we_run, E_WIN);
         if (sram_we_n) we_run = 0;
         // R4 read window
         if (!sram_oe_n) oe_lo_run++;
         if (sram_oe_n && !p_oe)
            check(oe_lo_run == E_RD, "R4 read window", oe_lo_run, E_RD);
         if (sram_oe_n) oe_lo_run = 0;
         if (sram_oe_n) oe_hi_run = (oe_hi_run < 1000) ? oe_hi_run + 1 : 1000;
         else oe_hi_run = 0;
         // R10 busy span
         if (!host_ready) busy_run++;
         if (host_ready && !p_rdy)
            check(busy_run >= E_CYC, "R10 busy span", busy_run, E_CYC);
         if (host_ready) busy_run = 0;
         // R4 single valid pulse
         if (host_rvalid) n_rv++;
         if (host_rvalid && p_rv)
            check(1'b0, "R4 valid longer than one cycle", 2, 1);
      end
      p_we  = sram_we_n;
      p_oe  = sram_oe_n;
      p_cs  = sram_cs_n;
      p_rdy = host_ready;
      p_rv  = host_rvalid;
   end

   // ---------------- host access task (called at a falling edge) ----------------
   task automatic do_acc(input bit we, input logic [17:0] a, input logic [3:0] d);
      logic [3:0] exp_d;
      host_req   = 1'b1;
      host_we    = we;
      host_addr  = a;
      host_wdata = d;
      while (!host_ready) @(negedge clk);    // R8 held off while busy
      @(posedge clk);
      cur_addr  = a;
      cur_wdata = we ? d : 4'h0;
      n_req++;
      @(negedge clk);
      host_req = 1'b0;
      if (we) begin
         exp_mem[int'(a)] = d;
      end else begin
         n_reads++;
         exp_d = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : dflt(a);
         for (int i = 0; i < 50 && !host_rvalid; i++) @(negedge clk);
         check(host_rvalid == 1'b1, "R4 valid seen", host_rvalid, 1);
         check(host_rdata == exp_d, "R4 read data", host_rdata, exp_d);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      // R1 during reset
      check(sram_cs_n && sram_we_n && sram_oe_n, "R1 pins in reset",
            {sram_cs_n, sram_we_n, sram_oe_n}, 3'b111);
      check(host_ready && !host_rvalid, "R1 ready in reset",
            {host_ready, host_rvalid}, 2'b10);
      rst_n = 1'b1;
      @(negedge clk);
      check(sram_cs_n && sram_we_n && sram_oe_n, "R1 pins after reset",
            {sram_cs_n, sram_we_n, sram_oe_n}, 3'b111);
      check(host_ready && !host_rvalid, "R1 ready after reset",
            {host_ready, host_rvalid}, 2'b10);
      started = 1;

      // directed corners
      do_acc(1'b1, 18'h00000, 4'hA);
      do_acc(1'b0, 18'h00000, 4'h0);
      do_acc(1'b1, 18'h3FFFF, 4'h5);
      do_acc(1'b0, 18'h3FFFF, 4'h0);
      do_acc(1'b0, 18'h00100, 4'h0);       // unwritten word
      do_acc(1'b1, 18'h00100, 4'hC);       // read then write: R5 wait
      do_acc(1'b0, 18'h00100, 4'h0);
      do_acc(1'b1, 18'h00007, 4'h1);       // back-to-back writes
      do_acc(1'b1, 18'h00007, 4'hE);
      do_acc(1'b0, 18'h00007, 4'h0);

      // constrained random traffic
      for (int k = 0; k < 300; k++) begin
         logic [17:0] a;
         a = ($urandom % 4 == 0) ? 18'($urandom) : {14'h0, 4'($urandom)};
         do_acc(1'($urandom), a, 4'($urandom));
         repeat ($urandom % 3) @(negedge clk);
      end
      repeat (6) @(negedge clk);

      check(enc_bad == 0, "R2 pin encoding", enc_bad, 0);
      check(rdy_bad == 0, "R7 ready in standby", rdy_bad, 0);
      check(addr_bad == 0, "R9 address", addr_bad, 0);
      check(drv_bad == 0, "R6 write word on bus", drv_bad, 0);
      check(n_cs_fall == n_req, "R8 one access per request", n_cs_fall, n_req);
      check(n_rv == n_reads, "R8 one valid per read", n_rv, n_reads);
      summary();
      $finish;
   end

endmodule